// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Per-Word Validity

This block sits between a 32-bit processor load/store port and a simple memory request/response port. Every incoming byte address is first tested against a cacheable window, given by a base and a high address. The window must cover a power-of-two number of bytes and start on a multiple of its own size. Addresses inside the window are served through a direct-mapped cache. All other addresses pass straight through to memory. The top module checks the window, the cache size (64 bytes to 64 KB) and the line length (4 or 8 words) when it starts, and reports a bad combination.

Inside the window, the address is split into a tag and a cache address. The cache address is further split into a line index, a word-within-line index and a 2-bit byte offset. The tag width is log2 of the window size minus log2 of the cache size. With the defaults (a 16 KB window at 0x0040_0000, a 2 KB cache and 4-word lines) this gives a 3-bit tag, 128 line entries and 512 data words.

Each line entry stores its tag, one valid bit per word and one valid bit for the whole line. Because of the per-word bits, a load miss fetches only the missing word. Stores are written through to memory and never allocate a line.

Top module: `wv_dcache`

## Requirements
- R1: An address is cacheable exactly when WIN_BASE <= address <= WIN_HIGH. Loads outside that range never set rspHit, even when repeated, and even one word below the base or one word above the high address.
- R2: The line index is taken from address bits [CACHE_BITS-1 : 2+log2(LINE_WORDS)] and the tag from bits [WIN_BITS-1 : CACHE_BITS]. Two cacheable addresses that differ only in the tag share one entry, so loading one evicts the other.
- R3: After reset, reqReady stays low for exactly one cycle per line entry (128 with the defaults) while every line is invalidated. The first load to any address after reset misses.
- R4: A cacheable load hits when the line is valid, the stored tag matches and the addressed word's valid bit is set. The stored word is then returned with rspValid and rspHit high in the cycle after acceptance, and no memory request is issued.
- R5: A load miss issues exactly one memory read, with memReqWe low, memReqBe = 4'b1111 and the word-aligned address. memRspData is returned on rspData, with rspValid high and rspHit low, in the cycle memRspValid is high.
- R6: A cacheable miss fills only the addressed word and sets only that word's valid bit. Another word of the same line still misses until it is loaded itself.
- R7: When a fill brings a new tag, or fills an invalid line, every other word-valid bit of that line is cleared. A different word of the new line therefore misses rather than returning data from the old tag.
- R8: Non-cacheable loads are never stored in the cache. Each one produces its own memory read.
- R9: Every store produces exactly one memory write carrying its word-aligned address, reqBe and reqWdata. A store gives no rspValid. reqReady stays low until the memory has accepted the write.
- R10: A store that hits updates each byte lane i of the cached word for which reqBe[i] is 1, and leaves the other lanes as they were. A later load hits and returns the merged word.
- R11: A store that misses does not allocate. A later load of the same address still misses.
- R12: While memReqValid is high and memReqReady is low, memReqValid, memReqAddr and memReqWe are held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Processor request valid |
| reqReady | output | 1 | Cache can accept a request |
| reqAddr | input | 32 | Request byte address |
| reqWe | input | 1 | 1 = store, 0 = load |
| reqBe | input | 4 | Store byte enables, bit i is byte lane i |
| reqWdata | input | 32 | Store data |
| rspValid | output | 1 | Load data valid strobe |
| rspHit | output | 1 | The load was served from the cache |
| rspData | output | 32 | Load data |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 32 | Word-aligned memory address |
| memReqWe | output | 1 | Memory write |
| memReqBe | output | 4 | Memory byte enables |
| memReqWdata | output | 32 | Memory write data |
| memRspValid | input | 1 | Memory read data valid |
| memRspData | input | 32 | Memory read data |

## Verification
A word-valid bit that is wrongly left set shows up as a hit that returns stale data from an old tag. It is visible on rspData one cycle after the load is accepted. A bit that is lost, or a line that is not cleared, shows up instead as an extra memory read, or a missing one, in the second or third cycle after acceptance. A store merge that goes wrong stays hidden until the next load of that word. That load then hits and returns a word that differs from the memory model.

// File: rtl/wv_dcache_pkg.sv
package wv_dcache_pkg;

  typedef enum logic [2:0] {
    ST_SWEEP,
    ST_IDLE,
    ST_LOOKUP,
    ST_RDREQ,
    ST_RDWAIT,
    ST_WRREQ
  } ctrlState_t;

  // strobes issued by control towards the datapath
  typedef struct packed {
    logic capture;     // latch request, read tag and data arrays
    logic sweepStep;   // invalidate the entry at the sweep pointer
    logic storeMerge;  // merge store bytes into the cached word
    logic fill;        // write memory word and update the line entry
  } dpStrobe_t;

endpackage

// File: rtl/wv_dcache_dp.sv
module wv_dcache_dp
  import wv_dcache_pkg::*;
#(
  parameter logic [31:0] WIN_BASE    = 32'h0040_0000,
  parameter logic [31:0] WIN_HIGH    = 32'h0040_3FFF,
  parameter int          CACHE_BYTES = 2048,
  parameter int          LINE_WORDS  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [31:0]      reqAddr,
  input  logic             reqWe,
  input  logic [3:0]       reqBe,
  input  logic [31:0]      reqWdata,
  input  logic [31:0]      memRspData,
  output logic             sweepLast,
  output logic             curCacheable,
  output logic             lookupHit,
  output logic             curWe,
  output logic [31:0]      curWordAddr,
  output logic [3:0]       curBe,
  output logic [31:0]      curWdata,
  output logic [31:0]      rdWord
);

  localparam logic [31:0] WIN_SPAN   = WIN_HIGH - WIN_BASE + 32'd1;
  localparam logic [31:0] WIN_MASK   = WIN_SPAN - 32'd1;
  localparam int          WIN_BITS   = $clog2(WIN_SPAN);
  localparam int          CACHE_BITS = $clog2(CACHE_BYTES);
  localparam int          WORD_BITS  = $clog2(LINE_WORDS);
  localparam int          LINES      = CACHE_BYTES / (4 * LINE_WORDS);
  localparam int          LINE_BITS  = CACHE_BITS - 2 - WORD_BITS;
  localparam int          TAG_BITS   = WIN_BITS - CACHE_BITS;
  localparam int          DATA_WORDS = CACHE_BYTES / 4;
  localparam int          DIDX_BITS  = CACHE_BITS - 2;

  // captured request
  logic [31:0] curAddr;

  // line entry arrays and data array
  logic [TAG_BITS-1:0]   tagMem  [LINES];
  logic [LINE_WORDS-1:0] wvMem   [LINES];
  logic                  lvMem   [LINES];
  logic [31:0]           dataMem [DATA_WORDS];

  // registered read of the entry addressed at capture time
  logic [TAG_BITS-1:0]   rdTag;
  logic [LINE_WORDS-1:0] rdWv;
  logic                  rdLv;

  logic [LINE_BITS-1:0]  sweepIdx;

  // address fields of the captured request
  logic [LINE_BITS-1:0]  curLine;
  logic [WORD_BITS-1:0]  curWord;
  logic [TAG_BITS-1:0]   curTag;
  logic [DIDX_BITS-1:0]  curDidx;
  logic [LINE_BITS-1:0]  inLine;
  logic [DIDX_BITS-1:0]  inDidx;
  logic [LINE_WORDS-1:0] wordOh;
  logic                  sameLine;
  logic [LINE_WORDS-1:0] fillWv;
  logic [31:0]           mergedWord;

  assign curLine = curAddr[CACHE_BITS-1 -: LINE_BITS];
  assign curWord = curAddr[2 +: WORD_BITS];
  assign curTag  = curAddr[WIN_BITS-1 -: TAG_BITS];
  assign curDidx = curAddr[CACHE_BITS-1 : 2];
  assign inLine  = reqAddr[CACHE_BITS-1 -: LINE_BITS];
  assign inDidx  = reqAddr[CACHE_BITS-1 : 2];

  assign curCacheable = (curAddr & ~WIN_MASK) == WIN_BASE;
  assign wordOh       = LINE_WORDS'(1) << curWord;
  assign sameLine     = rdLv && (rdTag == curTag);
  assign fillWv       = sameLine ? (rdWv | wordOh) : wordOh;
  assign lookupHit    = curCacheable && sameLine && rdWv[curWord];

  assign curWordAddr  = {curAddr[31:2], 2'b00};
  assign sweepLast    = sweepIdx == LINE_BITS'(LINES - 1);

  // byte-lane merge of store data over the cached word
  for (genvar lane = 0; lane < 4; lane++) begin : g_lane
    assign mergedWord[8*lane +: 8] = curBe[lane] ? curWdata[8*lane +: 8]
                                                 : rdWord[8*lane +: 8];
  end

  // request capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      curWe    <= 1'b0;
      curBe    <= '0;
      curWdata <= '0;
    end else if (strobe.capture) begin
      curAddr  <= reqAddr;
      curWe    <= reqWe;
      curBe    <= reqBe;
      curWdata <= reqWdata;
    end
  end

  // invalidation sweep pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sweepIdx <= '0;
    end else if (strobe.sweepStep) begin
      sweepIdx <= sweepIdx + LINE_BITS'(1);
    end
  end

  // line entry arrays
  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      rdTag <= tagMem[inLine];
      rdWv  <= wvMem[inLine];
      rdLv  <= lvMem[inLine];
    end
    if (strobe.sweepStep) begin
      lvMem[sweepIdx] <= 1'b0;
      wvMem[sweepIdx] <= '0;
    end else if (strobe.fill) begin
      tagMem[curLine] <= curTag;
      wvMem[curLine]  <= fillWv;
      lvMem[curLine]  <= 1'b1;
    end
  end

  // data array
  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      rdWord <= dataMem[inDidx];
    end
    if (strobe.fill) begin
      dataMem[curDidx] <= memRspData;
    end else if (strobe.storeMerge) begin
      dataMem[curDidx] <= mergedWord;
    end
  end

endmodule

// File: rtl/wv_dcache_ctrl.sv
module wv_dcache_ctrl
  import wv_dcache_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       sweepLast,
  input  logic       curCacheable,
  input  logic       lookupHit,
  input  logic       curWe,
  input  logic       memReqReady,
  input  logic       memRspValid,
  output logic       reqReady,
  output logic       rspValid,
  output logic       rspHit,
  output logic       rspFromMem,
  output logic       memReqValid,
  output logic       memReqWe,
  output dpStrobe_t  strobe
);

  ctrlState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SWEEP;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    reqReady    = 1'b0;
    rspValid    = 1'b0;
    rspHit      = 1'b0;
    rspFromMem  = 1'b0;
    memReqValid = 1'b0;
    memReqWe    = 1'b0;
    unique case (state)
      ST_SWEEP: begin
        strobe.sweepStep = 1'b1;
        if (sweepLast) stateNext = ST_IDLE;
      end
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.capture = 1'b1;
          stateNext      = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (curWe) begin
          strobe.storeMerge = lookupHit;
          stateNext         = ST_WRREQ;
        end else if (lookupHit) begin
          rspValid  = 1'b1;
          rspHit    = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          stateNext = ST_RDREQ;
        end
      end
      ST_RDREQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateNext = ST_RDWAIT;
      end
      ST_RDWAIT: begin
        rspFromMem = 1'b1;
        if (memRspValid) begin
          rspValid    = 1'b1;
          strobe.fill = curCacheable;
          stateNext   = ST_IDLE;
        end
      end
      ST_WRREQ: begin
        memReqValid = 1'b1;
        memReqWe    = 1'b1;
        if (memReqReady) stateNext = ST_IDLE;
      end
      default: stateNext = ST_SWEEP;
    endcase
  end

endmodule

// File: rtl/wv_dcache.sv
module wv_dcache
  import wv_dcache_pkg::*;
#(
  parameter logic [31:0] WIN_BASE    = 32'h0040_0000,
  parameter logic [31:0] WIN_HIGH    = 32'h0040_3FFF,
  parameter int          CACHE_BYTES = 2048,
  parameter int          LINE_WORDS  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqAddr,
  input  logic        reqWe,
  input  logic [3:0]  reqBe,
  input  logic [31:0] reqWdata,
  output logic        rspValid,
  output logic        rspHit,
  output logic [31:0] rspData,
  output logic        memReqValid,
  input  logic        memReqReady,
  output logic [31:0] memReqAddr,
  output logic        memReqWe,
  output logic [3:0]  memReqBe,
  output logic [31:0] memReqWdata,
  input  logic        memRspValid,
  input  logic [31:0] memRspData
);

  localparam logic [31:0] WIN_SPAN = WIN_HIGH - WIN_BASE + 32'd1;

  // configuration rule: power-of-two aligned window larger than the cache
  initial begin : paramCheck
    assert ((WIN_SPAN != 0) && ((WIN_SPAN & (WIN_SPAN - 32'd1)) == 0)
            && ((WIN_BASE & (WIN_SPAN - 32'd1)) == 0)
            && (CACHE_BYTES >= 64) && (CACHE_BYTES <= 65536)
            && ((CACHE_BYTES & (CACHE_BYTES - 1)) == 0)
            && (LINE_WORDS == 4 || LINE_WORDS == 8)
            && (WIN_SPAN > 32'(CACHE_BYTES)))
      else $error("wv_dcache: illegal window or cache geometry");
  end

  dpStrobe_t   strobe;
  logic        sweepLast;
  logic        curCacheable;
  logic        lookupHit;
  logic        curWe;
  logic        rspFromMem;
  logic [3:0]  curBe;
  logic [31:0] rdWord;

  wv_dcache_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .sweepLast    (sweepLast),
    .curCacheable (curCacheable),
    .lookupHit    (lookupHit),
    .curWe        (curWe),
    .memReqReady  (memReqReady),
    .memRspValid  (memRspValid),
    .reqReady     (reqReady),
    .rspValid     (rspValid),
    .rspHit       (rspHit),
    .rspFromMem   (rspFromMem),
    .memReqValid  (memReqValid),
    .memReqWe     (memReqWe),
    .strobe       (strobe)
  );

  wv_dcache_dp #(
    .WIN_BASE    (WIN_BASE),
    .WIN_HIGH    (WIN_HIGH),
    .CACHE_BYTES (CACHE_BYTES),
    .LINE_WORDS  (LINE_WORDS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqAddr      (reqAddr),
    .reqWe        (reqWe),
    .reqBe        (reqBe),
    .reqWdata     (reqWdata),
    .memRspData   (memRspData),
    .sweepLast    (sweepLast),
    .curCacheable (curCacheable),
    .lookupHit    (lookupHit),
    .curWe        (curWe),
    .curWordAddr  (memReqAddr),
    .curBe        (curBe),
    .curWdata     (memReqWdata),
    .rdWord       (rdWord)
  );

  assign memReqBe = curWe ? curBe : 4'hF;
  assign rspData  = rspFromMem ? memRspData : rdWord;

endmodule

// File: rtl/wv_dcache_chk.sv
module wv_dcache_chk #(
  parameter logic [31:0] WIN_BASE = 32'h0040_0000,
  parameter logic [31:0] WIN_HIGH = 32'h0040_3FFF,
  parameter int          LINES    = 128
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic [31:0] reqAddr,
  input logic        reqWe,
  input logic        rspValid,
  input logic        rspHit,
  input logic        memReqValid,
  input logic        memReqReady,
  input logic [31:0] memReqAddr,
  input logic        memReqWe
);

  logic [31:0] sinceReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        sinceReset <= '0;
    else if (sinceReset < 32'(LINES)) sinceReset <= sinceReset + 32'd1;
  end

  // R3: no acceptance before the invalidation sweep has covered every line
  p_sweep_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> sinceReset >= 32'(LINES));

  // R4: a hit answers exactly one cycle after a load was accepted
  p_hit_latency_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> rspValid && $past(reqValid && reqReady && !reqWe));

  // R1: only addresses inside the window can hit
  p_hit_in_window_r1: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> ($past(reqAddr) >= WIN_BASE && $past(reqAddr) <= WIN_HIGH));

  // R9: an accepted store reaches the memory port two cycles later
  p_store_forward_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWe) |=> ##1 (memReqValid && memReqWe));

  // R12: a stalled memory request is held
  p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqWe)));

  // R5: no new request is accepted while load data is returned
  p_busy_on_rsp_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

endmodule

bind wv_dcache wv_dcache_chk #(
  .WIN_BASE (WIN_BASE),
  .WIN_HIGH (WIN_HIGH),
  .LINES    (CACHE_BYTES / (4 * LINE_WORDS))
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .reqAddr     (reqAddr),
  .reqWe       (reqWe),
  .rspValid    (rspValid),
  .rspHit      (rspHit),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqAddr  (memReqAddr),
  .memReqWe    (memReqWe)
);

// File: tb/wv_dcache_test.sv
module wv_dcache_test;

  localparam int CLK_PERIOD = 10;
  localparam int LINES      = 128;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        reqWe = 1'b0;
  logic [3:0]  reqBe = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic        rspHit;
  logic [31:0] rspData;
  logic        memReqValid;
  logic        memReqReady;
  logic [31:0] memReqAddr;
  logic        memReqWe;
  logic [3:0]  memReqBe;
  logic [31:0] memReqWdata;
  logic        memRspValid;
  logic [31:0] memRspData;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wv_dcache uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWe(reqWe), .reqBe(reqBe), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspHit(rspHit), .rspData(rspData),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memReqWe(memReqWe), .memReqBe(memReqBe),
    .memReqWdata(memReqWdata), .memRspValid(memRspValid),
    .memRspData(memRspData)
  );

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [31:0] memW [logic [31:0]];
  int memLat = 0;
  int readyGap = 0;
  int rdCnt = 0;
  int wrCnt = 0;
  int holdFails = 0;
  logic [31:0] lastRdAddr = '0;
  logic [31:0] lastWrAddr = '0;
  logic [3:0]  lastWrBe = '0;
  logic [31:0] lastWrData = '0;

  function automatic logic [31:0] memInit(input logic [31:0] a);
    return {a[31:16] + 16'h1234, a[15:0] ^ 16'h5A5A};
  endfunction

  function automatic logic [31:0] modelRead(input logic [31:0] a);
    if (memW.exists(a)) return memW[a];
    return memInit(a);
  endfunction

  initial begin
    bit fire, fWe, holdPend, pendOn;
    logic [31:0] fAddr, fData, holdAddr, pendAddr, cur;
    logic [3:0] fBe;
    int pendCnt, cyc;
    memReqReady = 1'b1; memRspValid = 1'b0; memRspData = '0;
    holdPend = 1'b0; pendOn = 1'b0; pendCnt = 0; cyc = 0;
    holdAddr = '0; pendAddr = '0;
    forever begin
      @(posedge clk);
      fire = memReqValid && memReqReady && rstN;
      fAddr = memReqAddr; fWe = memReqWe; fBe = memReqBe; fData = memReqWdata;
      if (holdPend && rstN && (!memReqValid || memReqAddr != holdAddr)) holdFails++;
      holdPend = memReqValid && !memReqReady && rstN;
      holdAddr = memReqAddr;
      #1;
      memRspValid = 1'b0;
      if (pendOn) begin
        if (pendCnt == 0) begin
          memRspValid = 1'b1; memRspData = modelRead(pendAddr); pendOn = 1'b0;
        end else pendCnt--;
      end
      if (fire) begin
        if (fWe) begin
          cur = modelRead(fAddr);
          for (int b = 0; b < 4; b++) if (fBe[b]) cur[8*b +: 8] = fData[8*b +: 8];
          memW[fAddr] = cur;
          wrCnt++; lastWrAddr = fAddr; lastWrBe = fBe; lastWrData = fData;
        end else begin
          rdCnt++; lastRdAddr = fAddr;
          if (memLat == 0) begin
            memRspValid = 1'b1; memRspData = modelRead(fAddr);
          end else begin
            pendOn = 1'b1; pendCnt = memLat - 1; pendAddr = fAddr;
          end
        end
      end
      cyc++;
      memReqReady = (cyc % (readyGap + 1)) == 0;
    end
  end

  // ---------------- request tasks ----------------
  task automatic doLoad(input logic [31:0] a, input bit expHit, input string tag);
    int waitCyc, rd0;
    logic [31:0] exp;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    rd0 = rdCnt;
    exp = modelRead({a[31:2], 2'b00});
    reqValid = 1'b1; reqAddr = a; reqWe = 1'b0; reqBe = 4'h0;
    waitCyc = 0;
    do begin
      @(negedge clk);
      reqValid = 1'b0;
      waitCyc++;
    end while (!rspValid && waitCyc < 60);
    check(rspValid, {tag, " rspValid"}, 32'(rspValid), 32'd1);
    check(rspHit == expHit, {tag, " rspHit"}, 32'(rspHit), 32'(expHit));
    check(rspData == exp, {tag, " rspData"}, rspData, exp);
    check((rdCnt - rd0) == (expHit ? 0 : 1), {tag, " memory reads"},
          32'(rdCnt - rd0), expHit ? 32'd0 : 32'd1);
    if (expHit) check(waitCyc == 1, {tag, " hit latency"}, 32'(waitCyc), 32'd1);
    else check(lastRdAddr == {a[31:2], 2'b00}, {tag, " read address"},
               lastRdAddr, {a[31:2], 2'b00});
  endtask

  task automatic doStore(input logic [31:0] a, input logic [3:0] be,
                         input logic [31:0] d, input string tag);
    int waitCyc, wr0;
    bit sawRsp;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    wr0 = wrCnt;
    reqValid = 1'b1; reqAddr = a; reqWe = 1'b1; reqBe = be; reqWdata = d;
    waitCyc = 0; sawRsp = 1'b0;
    do begin
      @(negedge clk);
      reqValid = 1'b0;
      if (rspValid) sawRsp = 1'b1;
      waitCyc++;
    end while (!reqReady && waitCyc < 60);
    reqWe = 1'b0;
    check(!sawRsp, {tag, " no rspValid"}, 32'(sawRsp), 32'd0);
    check((wrCnt - wr0) == 1, {tag, " write count"}, 32'(wrCnt - wr0), 32'd1);
    check(lastWrAddr == {a[31:2], 2'b00}, {tag, " write address"},
          lastWrAddr, {a[31:2], 2'b00});
    check(lastWrBe == be, {tag, " write byte enables"}, 32'(lastWrBe), 32'(be));
    check(lastWrData == d, {tag, " write data"}, lastWrData, d);
  endtask

  task automatic resetAndSweep(input string tag);
    int n;
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(!reqReady && !rspValid && !memReqValid, {tag, " outputs idle in reset"},
          {29'd0, reqReady, rspValid, memReqValid}, 32'd0);
    rstN = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!reqReady && n < 1000);
    check(n == LINES, {tag, " sweep length"}, 32'(n), 32'(LINES));
  endtask

  // ---------------- vector table ----------------
  typedef struct packed {
    logic        isStore;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic        expHit;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0040_0100, 4'h0, 32'h0, 1'b0},  //  0 R5 first load misses
    '{1'b0, 32'h0040_0100, 4'h0, 32'h0, 1'b1},  //  1 R4 now hits
    '{1'b0, 32'h0040_0104, 4'h0, 32'h0, 1'b0},  //  2 R6 other word still invalid
    '{1'b0, 32'h0040_0104, 4'h0, 32'h0, 1'b1},  //  3 R6 filled word hits
    '{1'b0, 32'h0040_0102, 4'h0, 32'h0, 1'b1},  //  4 R4 byte offset ignored
    '{1'b0, 32'h0040_0900, 4'h0, 32'h0, 1'b0},  //  5 R2 same line, other tag
    '{1'b0, 32'h0040_0904, 4'h0, 32'h0, 1'b0},  //  6 R7 old word bits cleared
    '{1'b0, 32'h0040_0100, 4'h0, 32'h0, 1'b0},  //  7 R2 evicted
    '{1'b0, 32'h0050_0000, 4'h0, 32'h0, 1'b0},  //  8 R8 outside window
    '{1'b0, 32'h0050_0000, 4'h0, 32'h0, 1'b0},  //  9 R8 not cached
    '{1'b0, 32'h003F_FFFC, 4'h0, 32'h0, 1'b0},  // 10 R1 below base
    '{1'b0, 32'h003F_FFFC, 4'h0, 32'h0, 1'b0},  // 11 R1 below base again
    '{1'b0, 32'h0040_3FFC, 4'h0, 32'h0, 1'b0},  // 12 R1 last window word
    '{1'b0, 32'h0040_3FFC, 4'h0, 32'h0, 1'b1},  // 13 R1 last window word cached
    '{1'b0, 32'h0040_4000, 4'h0, 32'h0, 1'b0},  // 14 R1 first word above
    '{1'b0, 32'h0040_4000, 4'h0, 32'h0, 1'b0},  // 15 R1 above not cached
    '{1'b1, 32'h0040_0100, 4'h3, 32'hDEAD_BEEF, 1'b0},  // 16 R9 R10 store hit
    '{1'b0, 32'h0040_0100, 4'h0, 32'h0, 1'b1},  // 17 R10 merged word hits
    '{1'b1, 32'h0040_0200, 4'hF, 32'h1357_9BDF, 1'b0},  // 18 R9 store miss
    '{1'b0, 32'h0040_0200, 4'h0, 32'h0, 1'b0},  // 19 R11 no allocate
    '{1'b1, 32'h0050_0000, 4'h8, 32'hAA00_0000, 1'b0},  // 20 R9 uncached store
    '{1'b0, 32'h0050_0000, 4'h0, 32'h0, 1'b0},  // 21 R8 sees written byte
    '{1'b0, 32'h0040_0204, 4'h0, 32'h0, 1'b0},  // 22 R6 neighbour word
    '{1'b0, 32'h0040_0200, 4'h0, 32'h0, 1'b1}   // 23 R4 earlier fill kept
  };

  initial begin
    string tag;
    // R3: reset state and sweep length
    resetAndSweep("R3 initial");

    for (int i = 0; i < NV; i++) begin
      tag = $sformatf("vec%0d", i);
      if (VECS[i].isStore) doStore(VECS[i].addr, VECS[i].be, VECS[i].wdata, tag);
      else doLoad(VECS[i].addr, VECS[i].expHit, tag);
    end

    // R5 R12: slow memory with stalls on the request side
    memLat = 3; readyGap = 2;
    doLoad(32'h0040_0300, 1'b0, "R5 slow miss");
    doLoad(32'h0040_0300, 1'b1, "R4 after slow fill");
    doStore(32'h0040_0300, 4'h4, 32'h00C3_0000, "R9 stalled store");
    doLoad(32'h0040_0300, 1'b1, "R10 merged after stall");
    memLat = 0; readyGap = 0;
    check(holdFails == 0, "R12 request held while stalled", 32'(holdFails), 32'd0);

    // R3: every line forgotten after a second reset
    resetAndSweep("R3 second");
    doLoad(32'h0040_0100, 1'b0, "R3 cached word misses after reset");
    doLoad(32'h0040_3FFC, 1'b0, "R3 last line misses after reset");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule